// File: doc/BRIEF.md
# Video Output Word Conditioner

This block is the last stage of a serial-video receive path. It takes the word-aligned 20-bit stream, with luma in the upper ten bits and chroma in the lower ten, together with horizontal and vertical blanking flags and timing-reference markers from upstream. It then produces the bus that leaves the chip. Within the active picture it can clamp reserved code values into the legal range. It can force both channels to their blanking levels. It also produces a one-word, active-low load pulse for an external FIFO, placed on either the end-of-active-video or the start-of-active-video reference word.

Clamping, muting and the load pulse all come from a single register stage, so the pulse always lines up with the data word it marks. Upstream logic supplies three markers: one on the first word of every timing reference (the 3FF preamble word), one on the end-of-active-video XYZ word, and one on the start-of-active-video XYZ word. The block tracks the picture region from these markers and does no timing extraction of its own.

Top module: `vid_egress`

## Requirements
- R1: While `rst` is high at a rising edge, the registered bus becomes luma 040 / chroma 200, `fifo_ld_n` becomes high, and the picture-region state clears.
- R2: Each word on `dout` and `fifo_ld_n` reflects the inputs sampled at the previous rising edge of `clk`, so the latency is one cycle.
- R3: A word counts as active when all of the following hold: a `sav_xyz` word came earlier, no `trs_start` word has arrived since, the current word is not itself a `trs_start` word, and both `h_blank` and `v_blank` are low.
- R4: With `protect_en` high, the block replaces active words 000–003 with 004 and active words 3FC–3FF with 3FB, in each lane on its own. All other active values pass through unchanged.
- R5: With `protect_en` low, active words pass through unchanged, including 000–003 and 3FC–3FF.
- R6: Words that are not active are never altered while `mute_n` is high. This covers blanking words, reference preamble and XYZ words, and lines with `v_blank` high.
- R7: While `mute_n` is low, the output word is luma 040 and chroma 200 whatever the input. Mute overrides remapping.
- R8: `fifo_ld_n` goes low for exactly the output word that carries an `eav_xyz` input word when `ld_at_eav` is high, or an `sav_xyz` input word when `ld_at_eav` is low. It is high for every other word, and muting does not affect it.
- R9: When `oe_n` is high, all 20 bits of `dout` are high impedance. When `oe_n` is low, they drive the registered word. This path is combinational.
- R10: Luma occupies bits [19:10] of `din` and `dout`, and chroma occupies bits [9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 20 | Input word, luma [19:10], chroma [9:0] |
| h_blank | input | 1 | Horizontal blanking flag for the current word |
| v_blank | input | 1 | Vertical blanking flag for the current word |
| trs_start | input | 1 | Marks the 3FF first word of any timing reference |
| eav_xyz | input | 1 | Marks the XYZ word of an end-of-active-video reference |
| sav_xyz | input | 1 | Marks the XYZ word of a start-of-active-video reference |
| protect_en | input | 1 | Enables clamping of reserved codes in active picture |
| mute_n | input | 1 | Low forces both channels to blanking levels |
| ld_at_eav | input | 1 | High places the load pulse on EAV, low on SAV |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 20 | Output word, tri-stated when `oe_n` is high |
| fifo_ld_n | output | 1 | One-word active-low FIFO load pulse |

## Verification
The hardest condition to reach is a reserved code value in the active region while the region boundaries are still correct. A 3FF preamble word that arrives inside the picture must end the region without being clamped itself. The stimulus builds full reference sequences (preamble, two zero words, XYZ) around an active span of 1024 words that sweeps every code value in both lanes, running the luma and chroma sweeps in opposite directions. This is repeated with clamping on and off, under mute, and with `v_blank` or `h_blank` raised. A reference that starts in the middle of the picture checks that the preamble passes untouched and that later words are no longer treated as active.

// File: rtl/vout_pkg.sv
package vout_pkg;

  // Marker bundle handed from the top to the region tracker.
  typedef struct packed {
    logic h_blank;
    logic v_blank;
    logic trs_start;
    logic eav_xyz;
    logic sav_xyz;
  } mark_t;

  // Lowest legal code for a lane of width w (004 for ten bits).
  function automatic int unsigned legal_lo(input int unsigned w);
    return 1 << (w - 8);
  endfunction

  // Highest legal code for a lane of width w (3FB for ten bits).
  function automatic int unsigned legal_hi(input int unsigned w);
    return (1 << w) - 1 - (1 << (w - 8));
  endfunction

endpackage

// File: rtl/vout_region.sv
module vout_region
  import vout_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mark_t mk,
  output logic  active
);

  logic in_pic;
  logic past_ok;

  // Region opens after a start-of-active XYZ word, closes on any preamble.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_pic  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (mk.trs_start)    in_pic <= 1'b0;
      else if (mk.sav_xyz) in_pic <= 1'b1;
    end
  end

  assign active = in_pic && !mk.trs_start && !mk.h_blank && !mk.v_blank;

  // R3
  pic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mk.trs_start) |-> !in_pic);

  // R3
  pic_set_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mk.sav_xyz && !mk.trs_start) |-> in_pic);

endmodule

// File: rtl/vout_clamp.sv
module vout_clamp
  import vout_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         en,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  localparam int unsigned LO_I = legal_lo(W);
  localparam int unsigned HI_I = legal_hi(W);
  localparam logic [W-1:0] LO = LO_I[W-1:0];
  localparam logic [W-1:0] HI = HI_I[W-1:0];

  always_comb begin
    if (en && (x < LO))      y = LO;
    else if (en && (x > HI)) y = HI;
    else                     y = x;
  end

endmodule

// File: rtl/vout_outstage.sv
module vout_outstage
  import vout_pkg::*;
#(
  parameter int unsigned W     = 10,
  parameter int unsigned LANES = 2,
  parameter logic [W*LANES-1:0] BLANK = {10'h040, 10'h200}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W*LANES-1:0] din,
  input  logic               active,
  input  logic               protect_en,
  input  logic               mute_n,
  input  logic               ld_at_eav,
  input  logic               eav_xyz,
  input  logic               sav_xyz,
  output logic [W*LANES-1:0] q,
  output logic               ld_n
);

  localparam int unsigned LO_I = legal_lo(W);
  localparam int unsigned HI_I = legal_hi(W);

  logic past_ok;
  logic clamp_en;

  assign clamp_en = active && protect_en;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0] fixed;
      logic [W-1:0] lane_q;

      vout_clamp #(.W(W)) u_clamp (
        .en (clamp_en),
        .x  (din[g*W +: W]),
        .y  (fixed)
      );

      always_ff @(posedge clk) begin
        if (rst)          lane_q <= BLANK[g*W +: W];
        else if (!mute_n) lane_q <= BLANK[g*W +: W];
        else              lane_q <= fixed;
      end

      assign q[g*W +: W] = lane_q;

      // R4
      clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(mute_n && active && protect_en) |->
          (int'(lane_q) >= LO_I && int'(lane_q) <= HI_I));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_n    <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      ld_n    <= !(ld_at_eav ? eav_xyz : sav_xyz);
      past_ok <= 1'b1;
    end
  end

  // R7
  mute_blank_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(mute_n) |-> q == BLANK);

  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mute_n && !active) |-> q == $past(din));

  // R8
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !ld_n |-> $past(eav_xyz || sav_xyz));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) && past_ok == 1'b0 && $fell(rst) |-> ld_n && q == BLANK);

endmodule

// File: rtl/vid_egress.sv
module vid_egress
  import vout_pkg::*;
#(
  parameter int unsigned LANE_W = 10,
  parameter logic [LANE_W-1:0] Y_BLANK = 10'h040,
  parameter logic [LANE_W-1:0] C_BLANK = 10'h200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*LANE_W-1:0] din,
  input  logic                h_blank,
  input  logic                v_blank,
  input  logic                trs_start,
  input  logic                eav_xyz,
  input  logic                sav_xyz,
  input  logic                protect_en,
  input  logic                mute_n,
  input  logic                ld_at_eav,
  input  logic                oe_n,
  output logic [2*LANE_W-1:0] dout,
  output logic                fifo_ld_n
);

  localparam int unsigned DW = 2 * LANE_W;

  mark_t             mk;
  logic              active;
  logic [DW-1:0]     q;

  assign mk = '{h_blank: h_blank, v_blank: v_blank, trs_start: trs_start,
                eav_xyz: eav_xyz, sav_xyz: sav_xyz};

  vout_region u_region (
    .clk    (clk),
    .rst    (rst),
    .mk     (mk),
    .active (active)
  );

  // Lane 1 is luma (upper bits), lane 0 chroma.
  vout_outstage #(
    .W     (LANE_W),
    .LANES (2),
    .BLANK ({Y_BLANK, C_BLANK})
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .active     (active),
    .protect_en (protect_en),
    .mute_n     (mute_n),
    .ld_at_eav  (ld_at_eav),
    .eav_xyz    (eav_xyz),
    .sav_xyz    (sav_xyz),
    .q          (q),
    .ld_n       (fifo_ld_n)
  );

  assign dout = oe_n ? {DW{1'bz}} : q;

endmodule

// File: tb/vid_egress_tb.sv
module vid_egress_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] y_in = '0, c_in = '0;
  logic hb = 1'b1, vb = 1'b0, ts = 1'b0, ea = 1'b0, sa = 1'b0;
  logic prot = 1'b0, mute_n = 1'b1, sel = 1'b1, oe_n = 1'b0;
  wire [19:0] dout;
  wire        ld_n;

  int errors = 0;
  int checks = 0;
  bit ref_pic = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_egress u_dut (
    .clk(clk), .rst(rst), .din({y_in, c_in}), .h_blank(hb), .v_blank(vb),
    .trs_start(ts), .eav_xyz(ea), .sav_xyz(sa), .protect_en(prot),
    .mute_n(mute_n), .ld_at_eav(sel), .oe_n(oe_n), .dout(dout),
    .fifo_ld_n(ld_n)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_lane(input logic [9:0] x, input logic a,
                                          input logic [9:0] blank);
    if (!mute_n) return blank;
    if (a && prot) begin
      if (x < 10'd4)    return 10'd4;
      if (x > 10'd1019) return 10'd1019;
    end
    return x;
  endfunction

  // Drive one word, then check the word that appears after the next edge (R2).
  task automatic word(input logic [9:0] y, input logic [9:0] c, input logic t,
                      input logic e, input logic s, input string req);
    logic a;
    logic [9:0] ey, ec;
    logic el;
    y_in = y; c_in = c; ts = t; ea = e; sa = s;
    a  = ref_pic && !t && !hb && !vb;
    ey = exp_lane(y, a, 10'h040);
    ec = exp_lane(c, a, 10'h200);
    el = !(sel ? e : s);
    if (t) ref_pic = 1'b0;
    else if (s) ref_pic = 1'b1;
    @(posedge clk); #1;
    chk(req, dout, {ey, ec});
    chk("R8 strobe", {19'b0, ld_n}, {19'b0, el});
  endtask

  task automatic trs(input logic is_eav, input string req);
    logic [9:0] xyz;
    xyz = is_eav ? 10'h274 : 10'h200;
    word(10'h3FF, 10'h3FF, 1'b1, 1'b0, 1'b0, req);
    word(10'h000, 10'h000, 1'b0, 1'b0, 1'b0, req);
    word(10'h000, 10'h000, 1'b0, 1'b0, 1'b0, req);
    word(xyz, xyz, 1'b0, is_eav, !is_eav, req);
  endtask

  // Full line: EAV, blanking with reserved codes, SAV, active sweep.
  task automatic line(input int n_act, input string req_act);
    hb = 1'b1;
    trs(1'b1, "R6 eav");
    word(10'h001, 10'h3FE, 1'b0, 1'b0, 1'b0, "R6 blank");
    word(10'h3FF, 10'h000, 1'b0, 1'b0, 1'b0, "R6 blank");
    trs(1'b0, "R6 sav");
    hb = 1'b0;
    for (int i = 0; i < n_act; i++)
      word(10'(i), 10'(1023 - i), 1'b0, 1'b0, 1'b0, req_act);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset data", dout, {10'h040, 10'h200});
    chk("R1 reset strobe", {19'b0, ld_n}, 20'd1);
    @(negedge clk);
    rst = 1'b0;

    // R4 exhaustive clamp, EAV strobe; R10 lanes swept oppositely
    prot = 1'b1; sel = 1'b1;
    line(1024, "R4 R10 clamp");
    // R5 no clamp, SAV strobe
    prot = 1'b0; sel = 1'b0;
    line(1024, "R5 pass");
    // R3 preamble mid-picture closes region; preamble itself untouched (R6)
    prot = 1'b1;
    line(4, "R4 clamp");
    trs(1'b1, "R6 mid preamble");
    word(10'h000, 10'h3FF, 1'b0, 1'b0, 1'b0, "R3 after close");
    // R3 h_blank inside region
    line(2, "R4 clamp");
    hb = 1'b1;
    word(10'h002, 10'h3FD, 1'b0, 1'b0, 1'b0, "R3 hblank");
    hb = 1'b0;
    word(10'h002, 10'h3FD, 1'b0, 1'b0, 1'b0, "R4 resume");
    // R6 vertical blanking line
    vb = 1'b1;
    line(8, "R6 vblank");
    for (int i = 1020; i < 1024; i++)
      word(10'(i), 10'(i), 1'b0, 1'b0, 1'b0, "R6 vblank");
    vb = 1'b0;
    // R7 mute with both strobe placements
    mute_n = 1'b0; sel = 1'b1;
    line(16, "R7 mute");
    sel = 1'b0;
    line(16, "R7 mute");
    mute_n = 1'b1;
    word(10'h3FF, 10'h001, 1'b0, 1'b0, 1'b0, "R7 unmute");
    // R9 output enable
    oe_n = 1'b1; #1;
    checks++;
    if (dout !== 20'hzzzzz) begin
      errors++;
      $display("FAIL R9 actual=%h expected=zzzzz", dout);
    end
    oe_n = 1'b0; #1;
    chk("R9 drive", dout, {10'h3FB, 10'h004});
    // R1 reset mid-line
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset again", dout, {10'h040, 10'h200});
    chk("R1 reset strobe", {19'b0, ld_n}, 20'd1);
    ref_pic = 1'b0;
    rst = 1'b0;
    word(10'h000, 10'h000, 1'b0, 1'b0, 1'b0, "R1 region cleared");
    finish_run();
  end
endmodule